// File: doc/BRIEF.md
# GPIO Pad Controller with Shared Interrupt Lines

This block manages a small set of general-purpose pads, organised in groups of up to fifteen. Software reaches it through a plain 32-bit register port. Each pad has two configuration words. The first word holds the software-driven output level, the synchronised input level and the choice of interrupt line. The second word holds the trigger mode and an input-invert flag.

Pads do not own interrupt bits. Each pad picks one of sixteen shared lines, and every event it detects sets that line's bit in a status register. Software clears a status bit by writing 1 to it. A mask register gates the status bits into a single combined interrupt output.

The number of groups and the pad count of each group are parameters. Pad slots at or beyond their group's count do not exist. The `pad_in` and `pad_out` vectors carry one bit per slot, indexed group*15 + position, and bits for absent slots are unused.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: After reset the status and mask registers read zero, every configuration field reads zero, `pad_out` is all zeros and `irq` is low.
- R2: In configuration word 0, bit 1 is read/write and drives `pad_out` for its pad, and bits 31:28 are read/write and hold the selected line. Bit 0 is read-only and returns the input level after the two-flop synchroniser. All other bits read zero.
- R3: Configuration word 0 of pad position i in group g sits at byte address 0x4400 + 0x400*g + 8*i, and configuration word 1 sits 4 bytes above it. Status is at 0x300 and mask at 0x380, each using bits 15:0, one bit per line.
- R4: An address that names a position at or beyond its group's pad count, or a group beyond the last, reads as zero. Writes to it change no output, and input changes on such slots never set a status bit.
- R5: Bits 2:0 of word 1 select the trigger: 1 is falling edge, 2 is rising edge, 3 is both edges. If an input changes before clock edge k, the status bit is set from edge k+2 onward.
- R6: Mode 4 is level: the status bit is set on every cycle while the qualified input is high, so a clear only holds once the input has gone inactive.
- R7: Bit 6 of word 1 inverts the synchronised input before detection. With mode 4 this gives active-low level triggering.
- R8: Modes 0, 5, 6 and 7 never set a status bit.
- R9: Writing the status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R10: When a detected event and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R11: `irq` is high exactly when some status bit and its mask bit are both 1. The mask reads back as written.
- R12: A pad's events set only the status bit of the line in its word-0 bits 31:28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | NGROUPS*15 | Raw pad inputs, one per slot |
| pad_out | output | NGROUPS*15 | Software-driven pad output levels |
| irq | output | 1 | Combined masked interrupt |

## Verification
The hardest case to reach is a status write arriving in the very cycle in which a freshly synchronised edge fires on the same line. The stimulus reaches it by counting clock edges from the input change: it toggles a pad, waits exactly two edges and holds a clear write on the line across the third. Level-mode clears against a still-active input are also exercised, along with writes aimed at slots that do not exist. A long randomised phase then mixes configuration writes, status clears, mask changes and input toggles. Through all of this, a behavioural model is compared on every clock.

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int NGROUPS = 2,
  parameter logic [4*NGROUPS-1:0] GROUP_PADS = 8'h58
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [15:0]           bus_addr,
  input  logic                  bus_wr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NGROUPS*15-1:0] pad_in,
  output logic [NGROUPS*15-1:0] pad_out,
  output logic                  irq
);
  localparam int NSLOT = NGROUPS * 15;
  localparam int NLINES = 16;
  localparam logic [15:0] PAD_BASE = 16'h4400;
  localparam logic [15:0] STAT_ADDR = 16'h0300;
  localparam logic [15:0] MASK_ADDR = 16'h0380;

  logic [15:0] off;
  logic in_pad, wsel;
  logic [5:0] grp;
  logic [3:0] idx;
  logic [NLINES-1:0] irq_stat, irq_mask, hit;
  logic [NLINES-1:0] line_hit [NSLOT];
  logic [31:0] slot_rd [NSLOT];
  logic [NSLOT-1:0] sel;

  assign off = bus_addr - PAD_BASE;
  assign in_pad = (bus_addr >= PAD_BASE) && (off[9:7] == 3'd0) && (off[1:0] == 2'd0);
  assign grp = off[15:10];
  assign idx = off[6:3];
  assign wsel = off[2];

  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    for (genvar i = 0; i < 15; i++) begin : g_pos
      localparam int S = g * 15 + i;
      if (i < int'(GROUP_PADS[g*4 +: 4])) begin : g_pad
        logic tx, inv, s1, s2, qd, q, ev;
        logic [3:0] ln;
        logic [2:0] md;
        assign sel[S] = in_pad && (grp == 6'(g)) && (idx == 4'(i));
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            tx <= 1'b0; inv <= 1'b0; ln <= '0; md <= '0;
            s1 <= 1'b0; s2 <= 1'b0; qd <= 1'b0;
          end else begin
            s1 <= pad_in[S];
            s2 <= s1;
            qd <= q;
            if (bus_wr && sel[S]) begin
              if (wsel) begin
                md  <= bus_wdata[2:0];
                inv <= bus_wdata[6];
              end else begin
                tx <= bus_wdata[1];
                ln <= bus_wdata[31:28];
              end
            end
          end
        end
        assign q = s2 ^ inv;
        assign ev = (md == 3'd1 && !q && qd) || (md == 3'd2 && q && !qd) ||
                    (md == 3'd3 && (q != qd)) || (md == 3'd4 && q);
        assign line_hit[S] = ev ? (NLINES'(1) << ln) : '0;
        assign slot_rd[S] = wsel ? {25'd0, inv, 3'd0, md} : {ln, 26'd0, tx, s2};
        assign pad_out[S] = tx;
      end else begin : g_none
        assign sel[S] = 1'b0;
        assign line_hit[S] = '0;
        assign slot_rd[S] = '0;
        assign pad_out[S] = 1'b0;
      end
    end
  end

  always_comb begin
    hit = '0;
    for (int s = 0; s < NSLOT; s++) hit = hit | line_hit[s];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_stat <= '0;
      irq_mask <= '0;
    end else begin
      irq_stat <= (irq_stat & ~((bus_wr && bus_addr == STAT_ADDR) ? bus_wdata[15:0] : '0)) | hit;
      if (bus_wr && bus_addr == MASK_ADDR) irq_mask <= bus_wdata[15:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == STAT_ADDR) bus_rdata = {16'd0, irq_stat};
    if (bus_addr == MASK_ADDR) bus_rdata = {16'd0, irq_mask};
    for (int s = 0; s < NSLOT; s++)
      if (sel[s]) bus_rdata = slot_rd[s];
  end

  assign irq = |(irq_stat & irq_mask);
endmodule

// File: rtl/gpio_pad_ctrl_chk.sv
module gpio_pad_ctrl_chk #(
  parameter int NSLOT = 30
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [NSLOT-1:0] pad_out,
  input logic             irq,
  input logic [15:0]      irq_stat,
  input logic [15:0]      irq_mask,
  input logic [15:0]      hit
);
  a_r1_reset_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_stat == '0 && irq_mask == '0 && pad_out == '0));
  a_r2_out_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(pad_out));
  a_r9_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_stat & ~$past(irq_stat) & ~$past(hit)) == '0));
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((irq_stat & $past(hit)) == $past(hit)));
  a_r11_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_mask != '0));
endmodule

bind gpio_pad_ctrl gpio_pad_ctrl_chk #(.NSLOT(NSLOT)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .pad_out(pad_out), .irq(irq),
  .irq_stat(irq_stat), .irq_mask(irq_mask), .hit(hit)
);

// File: tb/test_gpio_pad_ctrl.sv
`timescale 1ns/1ps
module test_gpio_pad_ctrl;
  localparam int NS = 30;
  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NS-1:0] pad_in = '0, pad_out;
  logic irq;

  gpio_pad_ctrl i_gpio_pad_ctrl (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .irq(irq));

  always #4 clk = ~clk;

  int vectors = 0, errors = 0;
  string cur_req = "R1";
  bit chk_on = 0;

  int m_tx[NS], m_inv[NS], m_ln[NS], m_md[NS], m_s1[NS], m_s2[NS], m_qd[NS];
  int m_st = 0, m_mask = 0;

  function automatic int pads_in(int g);
    return (g == 0) ? 8 : 5;
  endfunction

  function automatic int slot_of(int a, output int w);
    int r, g, i;
    w = 0;
    if (a < 'h4400 || (a % 4) != 0) return -1;
    g = (a - 'h4400) / 1024;
    r = (a - 'h4400) % 1024;
    if (r >= 128 || g >= 2) return -1;
    i = r / 8;
    w = (r % 8) / 4;
    if (i >= pads_in(g)) return -1;
    return g * 15 + i;
  endfunction

  function automatic int ev_of(int s);
    int q, qd;
    q = m_s2[s] ^ m_inv[s];
    qd = m_qd[s];
    case (m_md[s])
      1: return int'(q == 0 && qd == 1);
      2: return int'(q == 1 && qd == 0);
      3: return int'(q != qd);
      4: return q;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int h, s, w;
    if (!rst_n) begin
      for (int k = 0; k < NS; k++) begin
        m_tx[k] = 0; m_inv[k] = 0; m_ln[k] = 0; m_md[k] = 0;
        m_s1[k] = 0; m_s2[k] = 0; m_qd[k] = 0;
      end
      m_st = 0; m_mask = 0;
    end else begin
      h = 0;
      for (int k = 0; k < NS; k++)
        if (slot_of('h4400 + 1024 * (k / 15) + 8 * (k % 15), w) == k && ev_of(k) != 0)
          h = h | (1 << m_ln[k]);
      if (bus_wr && bus_addr == 16'h0300) m_st = m_st & ~int'(bus_wdata[15:0]);
      m_st = m_st | h;
      if (bus_wr && bus_addr == 16'h0380) m_mask = int'(bus_wdata[15:0]);
      for (int k = 0; k < NS; k++) begin
        m_qd[k] = m_s2[k] ^ m_inv[k];
        m_s2[k] = m_s1[k];
        m_s1[k] = int'(pad_in[k]);
      end
      s = slot_of(int'(bus_addr), w);
      if (bus_wr && s >= 0) begin
        if (w == 1) begin
          m_md[s] = int'(bus_wdata[2:0]); m_inv[s] = int'(bus_wdata[6]);
        end else begin
          m_tx[s] = int'(bus_wdata[1]); m_ln[s] = int'(bus_wdata[31:28]);
        end
      end
    end
  end

  function automatic logic [31:0] model_rd(int a);
    int s, w;
    if (a == 'h300) return 32'(m_st);
    if (a == 'h380) return 32'(m_mask);
    s = slot_of(a, w);
    if (s < 0) return '0;
    if (w == 1) return 32'((m_inv[s] << 6) | m_md[s]);
    return 32'((m_ln[s] << 28) | (m_tx[s] << 1) | m_s2[s]);
  endfunction

  task automatic tick();
    logic [NS-1:0] eo;
    logic [31:0] er;
    @(negedge clk);
    if (chk_on) begin
      eo = '0;
      for (int k = 0; k < NS; k++) eo[k] = m_tx[k][0];
      er = model_rd(int'(bus_addr));
      vectors++;
      if (bus_rdata !== er || pad_out !== eo || irq !== ((m_st & m_mask) != 0)) begin
        errors++;
        $display("FAIL %s addr=%h rdata=%h/%h pad_out=%h/%h irq=%b/%b", cur_req, bus_addr,
                 bus_rdata, er, pad_out, eo, irq, (m_st & m_mask) != 0);
      end
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input int n);
    bus_addr = a;
    for (int k = 0; k < n; k++) tick();
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_on = 1;
    cur_req = "R1"; rd(16'h0300, 2); rd(16'h0380, 1); rd(16'h4418, 1); rd(16'h441C, 1);
    cur_req = "R2"; wr(16'h4418, 32'h5FFF_FFFE); rd(16'h4418, 2);
    pad_in[3] = 1'b1; rd(16'h4418, 4);
    cur_req = "R3"; wr(16'h4810, 32'h0000_0002); rd(16'h4810, 2); wr(16'h4814, 32'h0000_0041); rd(16'h4814, 1);
    wr(16'h4814, 32'h0); pad_in[17] = 1'b0;
    cur_req = "R4"; wr(16'h4450, 32'hFFFF_FFFF); rd(16'h4450, 1); wr(16'h4830, 32'h2); rd(16'h4830, 1);
    wr(16'h4C00, 32'h2); rd(16'h4C00, 1); wr(16'h4854, 32'h4); pad_in[20] = 1'b1; pad_in[25] = 1'b1; rd(16'h0300, 5);
    cur_req = "R11"; wr(16'h0380, 32'hFFFF_0024); rd(16'h0380, 2);
    cur_req = "R5"; pad_in[3] = 1'b0; rd(16'h0300, 4);
    wr(16'h441C, 32'h2); pad_in[3] = 1'b1; rd(16'h0300, 4); wr(16'h0300, 32'hFFFF); pad_in[3] = 1'b0; rd(16'h0300, 4);
    wr(16'h441C, 32'h1); pad_in[3] = 1'b1; rd(16'h0300, 4); pad_in[3] = 1'b0; rd(16'h0300, 4); wr(16'h0300, 32'h20);
    wr(16'h441C, 32'h3); pad_in[3] = 1'b1; rd(16'h0300, 4); wr(16'h0300, 32'h20); pad_in[3] = 1'b0; rd(16'h0300, 4);
    cur_req = "R10"; wr(16'h0300, 32'h20); pad_in[3] = 1'b1; tick(); tick(); wr(16'h0300, 32'h20); rd(16'h0300, 2);
    cur_req = "R6"; wr(16'h441C, 32'h4); rd(16'h0300, 2); wr(16'h0300, 32'h20); rd(16'h0300, 3);
    pad_in[3] = 1'b0; rd(16'h0300, 3); wr(16'h0300, 32'h20); rd(16'h0300, 3);
    cur_req = "R7"; wr(16'h441C, 32'h44); rd(16'h0300, 4); wr(16'h441C, 32'h0); wr(16'h0300, 32'h20); rd(16'h0300, 2);
    cur_req = "R8"; wr(16'h441C, 32'h5); pad_in[3] = 1'b1; rd(16'h0300, 4); pad_in[3] = 1'b0; rd(16'h0300, 4);
    wr(16'h441C, 32'h7); pad_in[3] = 1'b1; rd(16'h0300, 4);
    cur_req = "R12"; wr(16'h4408, 32'h9000_0000); wr(16'h440C, 32'h4); pad_in[1] = 1'b1; rd(16'h0300, 4);
    cur_req = "R9"; wr(16'h0300, 32'hFFFF_FC00); rd(16'h0300, 2); pad_in[1] = 1'b0; rd(16'h0300, 3);
    wr(16'h0300, 32'h0200); rd(16'h0300, 2); wr(16'h0300, 32'h0); rd(16'h0300, 1);
    cur_req = "R5";
    for (int n = 0; n < 3000; n++) begin
      int s, sel;
      if (($urandom % 3) == 0) pad_in[$urandom % NS] ^= 1'b1;
      sel = $urandom % 8;
      s = $urandom % 15;
      bus_addr = 16'h4400 + 16'(1024 * ($urandom % 3)) + 16'(8 * s) + 16'(4 * ($urandom % 2));
      if (sel == 0) bus_addr = 16'h0300;
      if (sel == 1) bus_addr = 16'h0380;
      bus_wdata = $urandom;
      bus_wr = (($urandom % 4) == 0);
      tick();
      bus_wr = 1'b0;
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule